// File: doc/BRIEF.md
# SPI Master with Slave-Select Control

This block is an SPI master that shifts 8-bit frames out on a serial clock and data line while capturing a reply from the slave, and whose focus is the handling of the active-low slave-select line. Software hands it transmit words over a valid/ready port and receives each reply as a one-cycle strobe with the captured byte. Words offered while a frame is still on the wire are held and chained into a continuous transfer.

The slave-select line can be used in three ways. Driven by hardware, it goes low as soon as the block is enabled and stays low until the block is disabled. Under software management, the internal select node follows a configuration bit and the pin is ignored. Used as an input, it watches for a competing master. In the hardware-driven case an optional pulse mode raises the line for one SCLK period between chained frames. If the internal select node is seen low while the master runs, the block records a mode fault, releases SCLK and MOSI and stays stopped until software clears the fault and cycles the enable.

Top module: `spi_nss_master`

## Requirements
- R1: After reset, mode_fault, busy and rx_valid are 0. With cfg_en low, nss_oe, sclk_oe, mosi_oe and tx_ready are 0.
- R2: Each frame is 8 bits. MOSI carries tx_data MSB first. The 8 MISO bits, first bit in the MSB, are returned in rx_data together with a one-cycle rx_valid strobe after the frame ends.
- R3: SCLK has a period of 4 system clocks and rests at cfg_cpol when no frame is in progress. With cfg_cpha=0 the slave samples on the leading edge; with cfg_cpha=1 it samples on the trailing edge. Each frame produces exactly 16 SCLK transitions.
- R4: With cfg_sw_sel=0 and cfg_nss_drive=1, nss_oe=1 and nss_o=0 from the first cycle the block is enabled, across idle time and frames, until it is disabled.
- R5: When cfg_en is low, nss_oe is 0, so the pin is released to high impedance instead of being driven high.
- R6: With cfg_sw_sel=1 the internal select follows cfg_sw_level and the nss_i pin is ignored. A held-low nss_i causes no fault, the pin is not driven (nss_oe=0), and cfg_sw_level=0 causes a mode fault.
- R7: With cfg_pulse=1, cfg_sw_sel=0, cfg_nss_drive=1 and cfg_cpha=0, nss_o is high for exactly 4 system clocks between two chained frames, and busy is low for those same 4 clocks.
- R8: cfg_pulse has no effect when cfg_cpha=1, when cfg_nss_drive=0 or when cfg_sw_sel=1: chained frames then follow one another with no gap and with nss_o not raised.
- R9: busy is high for exactly 32 system clocks per frame, and stays high without a break across frames chained without a pulse.
- R10: While the master is enabled, a low internal select (the nss_i pin when cfg_sw_sel=0 and cfg_nss_drive=0) sets mode_fault, drops sclk_oe and mosi_oe in the next cycle, and abandons the frame without an rx_valid.
- R11: mode_fault stays set until fault_clr is pulsed. After clearing, the master remains stopped (tx_ready=0) until cfg_en is taken low and then high again.
- R12: tx_ready is high only when the master is enabled, free of faults, and has no word already waiting; at most one word waits behind the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Block enable |
| cfg_sw_sel | input | 1 | 1: internal select comes from cfg_sw_level |
| cfg_sw_level | input | 1 | Software value of the internal select node |
| cfg_nss_drive | input | 1 | 1: block drives the select pin (hardware management) |
| cfg_pulse | input | 1 | Raise select for one SCLK period between chained frames |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: on trailing edge |
| fault_clr | input | 1 | Clears the mode-fault flag |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 8 | Transmit word |
| tx_ready | output | 1 | Transmit word can be accepted |
| rx_valid | output | 1 | One-cycle strobe, received word valid |
| rx_data | output | 8 | Received word |
| busy | output | 1 | Frame in progress |
| mode_fault | output | 1 | Competing-master fault flag |
| sclk | output | 1 | Serial clock |
| sclk_oe | output | 1 | Serial clock output enable |
| mosi | output | 1 | Serial data to slave |
| mosi_oe | output | 1 | Serial data output enable |
| miso | input | 1 | Serial data from slave |
| nss_o | output | 1 | Slave-select output level |
| nss_oe | output | 1 | Slave-select output enable |
| nss_i | input | 1 | Slave-select pin level seen by the block |

## Verification
Bursts run in all four clock modes against a slave model that captures MOSI on its own sampling edge and returns a separate byte per frame, so that bit order, the choice of sampling edge and the direction of data are each checked apart. Chained bursts are repeated with pulse mode in its single valid setting and in settings where it must be ignored; counting the cycles with busy low and with select high during the burst separates a one-period gap from a seamless chain. The select line is driven as an input low in mid-frame, and under software management both with the pin low and with the software level low. Together these separate pin sensing from software override, and the fault clear from the re-enable that must follow it.

// File: rtl/spi_nss_pkg.sv
package spi_nss_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2
    } xfer_state_e;

    // Serial clock level: resting level outside a frame, alternating
    // per half period inside it. CPHA=1 puts the first edge at half 0.
    function automatic logic sclk_level(input logic cpol, input logic cpha,
                                        input logic in_frame, input logic half_odd);
        if (!in_frame)
            return cpol;
        return cpol ^ (cpha ? ~half_odd : half_odd);
    endfunction

    // Value of the internal select node.
    function automatic logic internal_select(input logic sw_sel, input logic sw_level,
                                             input logic drive, input logic pin);
        if (sw_sel)
            return sw_level;
        if (drive)
            return 1'b1;
        return pin;
    endfunction

    // Gap between chained frames only in the one valid configuration.
    function automatic logic pulse_allowed(input logic pulse, input logic sw_sel,
                                           input logic drive, input logic cpha);
        return pulse && !sw_sel && drive && !cpha;
    endfunction

endpackage

// File: rtl/spi_nss_select.sv
module spi_nss_select
    import spi_nss_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic sw_sel,
    input  logic sw_level,
    input  logic drive,
    input  logic pin_in,
    input  logic fault_clr,
    output logic run,
    output logic fault,
    output logic pin_oe
);

    logic armed_q;
    logic fault_q;
    logic sel_node;
    logic trip;

    assign sel_node = internal_select(sw_sel, sw_level, drive, pin_in);
    assign trip     = en && armed_q && !fault_q && !sel_node;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b1;
            fault_q <= 1'b0;
        end else begin
            if (!en)
                armed_q <= 1'b1;
            if (trip) begin
                fault_q <= 1'b1;
                armed_q <= 1'b0;
            end else if (fault_clr) begin
                fault_q <= 1'b0;
            end
        end
    end

    assign run    = en && armed_q && !fault_q;
    assign fault  = fault_q;
    assign pin_oe = en && !sw_sel && drive;

endmodule

// File: rtl/spi_nss_engine.sv
module spi_nss_engine
    import spi_nss_pkg::*;
#(
    parameter int FRAME_BITS = 8,
    parameter int HALF_CYC   = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic                  cpol,
    input  logic                  cpha,
    input  logic                  gap_en,
    input  logic                  tx_valid,
    input  logic [FRAME_BITS-1:0] tx_data,
    output logic                  tx_ready,
    output logic                  rx_valid,
    output logic [FRAME_BITS-1:0] rx_data,
    output logic                  busy,
    output logic                  in_gap,
    output logic                  sclk,
    output logic                  mosi,
    input  logic                  miso
);

    localparam int HB        = $clog2(2 * FRAME_BITS);
    localparam int DB        = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int GB        = (HALF_CYC > 1) ? $clog2(2 * HALF_CYC) : 1;
    localparam int LAST_HALF = 2 * FRAME_BITS - 1;
    localparam int GAP_LAST  = 2 * HALF_CYC - 1;

    xfer_state_e           state;
    logic [HB-1:0]         half;
    logic [DB-1:0]         div;
    logic [GB-1:0]         gcnt;
    logic [FRAME_BITS-1:0] sh_tx;
    logic [FRAME_BITS-1:0] sh_rx;
    logic                  pend;
    logic [FRAME_BITS-1:0] pend_d;
    logic                  half_end;
    logic                  frame_end;
    logic                  do_load;

    assign half_end  = (div == DB'(HALF_CYC - 1));
    assign frame_end = (state == ST_XFER) && half_end && (half == HB'(LAST_HALF));
    assign tx_ready  = run && !pend;

    always_comb begin
        do_load = 1'b0;
        if (run) begin
            unique case (state)
                ST_IDLE: do_load = pend;
                ST_XFER: do_load = frame_end && pend && !gap_en;
                ST_GAP:  do_load = (gcnt == GB'(GAP_LAST));
                default: do_load = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            half     <= '0;
            div      <= '0;
            gcnt     <= '0;
            sh_tx    <= '0;
            sh_rx    <= '0;
            pend     <= 1'b0;
            pend_d   <= '0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (!run) begin
                state <= ST_IDLE;
                pend  <= 1'b0;
            end else begin
                if (tx_valid && tx_ready) begin
                    pend   <= 1'b1;
                    pend_d <= tx_data;
                end
                unique case (state)
                    ST_XFER: begin
                        div <= half_end ? '0 : div + DB'(1);
                        if (half_end) begin
                            // Sampling edge sits between the even and odd half.
                            if (!half[0])
                                sh_rx <= {sh_rx[FRAME_BITS-2:0], miso};
                            if (frame_end) begin
                                rx_valid <= 1'b1;
                                rx_data  <= sh_rx;
                                if (pend && gap_en) begin
                                    state <= ST_GAP;
                                    gcnt  <= '0;
                                end else if (!pend) begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                half <= half + HB'(1);
                                if (half[0])
                                    sh_tx <= {sh_tx[FRAME_BITS-2:0], 1'b0};
                            end
                        end
                    end
                    ST_GAP:  gcnt <= gcnt + GB'(1);
                    default: ;
                endcase
                if (do_load) begin
                    state <= ST_XFER;
                    half  <= '0;
                    div   <= '0;
                    sh_tx <= pend_d;
                    pend  <= 1'b0;
                end
            end
        end
    end

    assign busy   = (state == ST_XFER);
    assign in_gap = (state == ST_GAP);
    assign sclk   = sclk_level(cpol, cpha, busy, half[0]);
    assign mosi   = sh_tx[FRAME_BITS-1];

endmodule

// File: rtl/spi_nss_master.sv
module spi_nss_master
    import spi_nss_pkg::*;
#(
    parameter int FRAME_BITS = 8,
    parameter int HALF_CYC   = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_en,
    input  logic                  cfg_sw_sel,
    input  logic                  cfg_sw_level,
    input  logic                  cfg_nss_drive,
    input  logic                  cfg_pulse,
    input  logic                  cfg_cpol,
    input  logic                  cfg_cpha,
    input  logic                  fault_clr,
    input  logic                  tx_valid,
    input  logic [FRAME_BITS-1:0] tx_data,
    output logic                  tx_ready,
    output logic                  rx_valid,
    output logic [FRAME_BITS-1:0] rx_data,
    output logic                  busy,
    output logic                  mode_fault,
    output logic                  sclk,
    output logic                  sclk_oe,
    output logic                  mosi,
    output logic                  mosi_oe,
    input  logic                  miso,
    output logic                  nss_o,
    output logic                  nss_oe,
    input  logic                  nss_i
);

    logic run;
    logic gap_en;
    logic in_gap;

    assign gap_en = pulse_allowed(cfg_pulse, cfg_sw_sel, cfg_nss_drive, cfg_cpha);

    spi_nss_select u_sel (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg_en),
        .sw_sel    (cfg_sw_sel),
        .sw_level  (cfg_sw_level),
        .drive     (cfg_nss_drive),
        .pin_in    (nss_i),
        .fault_clr (fault_clr),
        .run       (run),
        .fault     (mode_fault),
        .pin_oe    (nss_oe)
    );

    spi_nss_engine #(
        .FRAME_BITS (FRAME_BITS),
        .HALF_CYC   (HALF_CYC)
    ) u_eng (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .cpol     (cfg_cpol),
        .cpha     (cfg_cpha),
        .gap_en   (gap_en),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .busy     (busy),
        .in_gap   (in_gap),
        .sclk     (sclk),
        .mosi     (mosi),
        .miso     (miso)
    );

    assign sclk_oe = run;
    assign mosi_oe = run;
    assign nss_o   = in_gap;

endmodule

// File: rtl/spi_nss_master_chk.sv
module spi_nss_master_chk (
    input logic clk,
    input logic rst,
    input logic cfg_en,
    input logic cfg_cpol,
    input logic fault_clr,
    input logic tx_ready,
    input logic rx_valid,
    input logic busy,
    input logic mode_fault,
    input logic sclk,
    input logic sclk_oe,
    input logic mosi_oe,
    input logic nss_o,
    input logic nss_oe
);

    // R10
    fault_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_fault) |-> (!sclk_oe && !mosi_oe));

    // R10
    fault_abort_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_fault) |=> !busy);

    // R11
    fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_fault && !fault_clr) |=> mode_fault);

    // R4
    nss_low_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && nss_oe) |-> !nss_o);

    // R3
    sclk_rest_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk == cfg_cpol));

    // R12
    ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> (cfg_en && !mode_fault));

    // R2
    rx_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

endmodule

bind spi_nss_master spi_nss_master_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_en     (cfg_en),
    .cfg_cpol   (cfg_cpol),
    .fault_clr  (fault_clr),
    .tx_ready   (tx_ready),
    .rx_valid   (rx_valid),
    .busy       (busy),
    .mode_fault (mode_fault),
    .sclk       (sclk),
    .sclk_oe    (sclk_oe),
    .mosi_oe    (mosi_oe),
    .nss_o      (nss_o),
    .nss_oe     (nss_oe)
);

// File: tb/sim_spi_nss_master.sv
module sim_spi_nss_master;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_en, cfg_sw_sel, cfg_sw_level, cfg_nss_drive;
    logic       cfg_pulse, cfg_cpol, cfg_cpha, fault_clr;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready, rx_valid, busy, mode_fault;
    logic [7:0] rx_data;
    logic       sclk, sclk_oe, mosi, mosi_oe, miso, nss_o, nss_oe, nss_i;

    int total = 0;
    int fails = 0;

    logic [7:0] pats [4];
    logic [7:0] txw  [4];
    logic [7:0] caps [4];
    logic [7:0] got  [4];
    logic [7:0] cap_sh;
    int   bitn, fidx, tog;
    logic slave_on = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_nss_master u0 (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_sw_sel(cfg_sw_sel),
        .cfg_sw_level(cfg_sw_level), .cfg_nss_drive(cfg_nss_drive),
        .cfg_pulse(cfg_pulse), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .fault_clr(fault_clr), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .busy(busy), .mode_fault(mode_fault), .sclk(sclk), .sclk_oe(sclk_oe),
        .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso), .nss_o(nss_o),
        .nss_oe(nss_oe), .nss_i(nss_i)
    );

    // Slave model: samples MOSI on its sampling edge, then presents its next bit.
    always @(sclk) begin
        logic lvl;
        lvl = sclk;
        tog++;
        #1;
        if (slave_on && busy && (((lvl != cfg_cpol) ? 1'b1 : 1'b0) ^ cfg_cpha)) begin
            cap_sh = {cap_sh[6:0], mosi};
            bitn++;
            if (bitn == 8) begin
                caps[fidx] = cap_sh;
                fidx++;
                bitn = 0;
                miso = pats[fidx % 4][7];
            end else begin
                miso = pats[fidx % 4][7 - bitn];
            end
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cfg_en = 0; cfg_sw_sel = 0; cfg_sw_level = 1; cfg_nss_drive = 1;
        cfg_pulse = 0; cfg_cpol = 0; cfg_cpha = 0; fault_clr = 0;
        tx_valid = 0; tx_data = 8'h00; miso = 0; nss_i = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!mode_fault, "R1 mode_fault", mode_fault, 0);
        check(!busy, "R1 busy", busy, 0);
        check(!rx_valid, "R1 rx_valid", rx_valid, 0);
        check(!nss_oe && !sclk_oe && !mosi_oe, "R1 output enables",
              {nss_oe, sclk_oe, mosi_oe}, 0);
        check(!tx_ready, "R1 tx_ready", tx_ready, 0);
    endtask

    task automatic t_burst(input int n, input logic pol, input logic pha,
                           input logic pls, input logic sws, input logic drv,
                           input string tag);
        int sent, rxn, bh, bl, nh;
        logic started, pok;
        pok = pls && !sws && drv && !pha;
        cfg_cpol = pol; cfg_cpha = pha; cfg_pulse = pls;
        cfg_sw_sel = sws; cfg_sw_level = 1; cfg_nss_drive = drv;
        nss_i = sws ? 1'b0 : 1'b1;   // R6: pin held low is ignored under software select
        fidx = 0; bitn = 0; cap_sh = 0; miso = pats[0][7];
        @(negedge clk);
        cfg_en = 1;
        @(negedge clk);
        if (!sws && drv)
            check(nss_oe && !nss_o, {"R4 select low once enabled ", tag}, {nss_oe, nss_o}, 2);
        if (sws)
            check(!nss_oe, {"R6 pin not driven ", tag}, nss_oe, 0);
        tog = 0; slave_on = 1;
        sent = 0; rxn = 0; bh = 0; bl = 0; nh = 0; started = 0;
        for (int cyc = 0; cyc < 3000 && rxn < n; cyc++) begin
            @(negedge clk);
            if (tx_valid) sent++;
            if (rx_valid) begin got[rxn] = rx_data; rxn++; end
            if (busy) begin started = 1; bh++; end
            else if (started && rxn < n) bl++;
            if (started && rxn < n && nss_oe && nss_o) nh++;
            tx_valid = tx_ready && (sent < n);
            tx_data = txw[sent];
        end
        tx_valid = 0;
        repeat (2) @(negedge clk);
        slave_on = 0;
        check(rxn == n, {"R2 frames completed ", tag}, rxn, n);
        for (int k = 0; k < n; k++) begin
            check(got[k] == pats[k], {"R2 rx_data ", tag}, got[k], pats[k]);
            check(caps[k] == txw[k], {"R2 R3 slave captured ", tag}, caps[k], txw[k]);
        end
        check(tog == 16 * n, {"R3 SCLK transitions ", tag}, tog, 16 * n);
        check(sclk == pol, {"R3 SCLK rest level ", tag}, sclk, pol);
        check(bh == 32 * n, {"R9 busy cycles ", tag}, bh, 32 * n);
        check(bl == (pok ? 4 * (n - 1) : 0), {"R7 R8 R9 gap cycles ", tag}, bl, pok ? 4 * (n - 1) : 0);
        check(nh == (pok ? 4 * (n - 1) : 0), {"R7 R8 select high cycles ", tag}, nh, pok ? 4 * (n - 1) : 0);
        check(!mode_fault, {"R6 R10 no fault ", tag}, mode_fault, 0);
        cfg_en = 0;
        @(negedge clk);
        check(!nss_oe, {"R5 released when disabled ", tag}, nss_oe, 0);
    endtask

    task automatic t_fault();
        int rxc;
        cfg_sw_sel = 0; cfg_nss_drive = 0; cfg_pulse = 0; cfg_cpol = 0; cfg_cpha = 0;
        nss_i = 1;
        @(negedge clk);
        cfg_en = 1;
        @(negedge clk);
        check(!nss_oe, "R10 input mode not driven", nss_oe, 0);
        tx_valid = 1; tx_data = 8'h5A;
        @(negedge clk);
        tx_valid = 0;
        repeat (10) @(negedge clk);
        check(busy, "R10 frame running before fault", busy, 1);
        nss_i = 0;
        @(negedge clk);
        nss_i = 1;
        check(mode_fault, "R10 fault raised", mode_fault, 1);
        check(!sclk_oe && !mosi_oe, "R10 outputs released", {sclk_oe, mosi_oe}, 0);
        check(!tx_ready, "R12 no ready while faulted", tx_ready, 0);
        rxc = 0;
        repeat (40) begin
            @(negedge clk);
            if (rx_valid) rxc++;
        end
        check(rxc == 0, "R10 frame abandoned", rxc, 0);
        check(!busy, "R10 idle after fault", busy, 0);
        check(mode_fault, "R11 fault sticky", mode_fault, 1);
        fault_clr = 1;
        @(negedge clk);
        fault_clr = 0;
        check(!mode_fault, "R11 fault cleared", mode_fault, 0);
        repeat (3) @(negedge clk);
        check(!tx_ready && !sclk_oe, "R11 stopped until re-enable", {tx_ready, sclk_oe}, 0);
        cfg_en = 0;
        @(negedge clk);
        cfg_en = 1;
        @(negedge clk);
        check(tx_ready && sclk_oe, "R11 R12 running after re-enable", {tx_ready, sclk_oe}, 3);
        cfg_en = 0;
        @(negedge clk);
    endtask

    task automatic t_soft();
        cfg_sw_sel = 1; cfg_sw_level = 1; cfg_nss_drive = 1; nss_i = 0;
        @(negedge clk);
        cfg_en = 1;
        repeat (3) @(negedge clk);
        check(!mode_fault, "R6 low pin ignored", mode_fault, 0);
        cfg_sw_level = 0;
        @(negedge clk);
        check(mode_fault, "R6 software level low faults", mode_fault, 1);
        cfg_sw_level = 1; cfg_en = 0; nss_i = 1;
        @(negedge clk);
        fault_clr = 1;
        @(negedge clk);
        fault_clr = 0;
        check(!mode_fault, "R11 cleared after software fault", mode_fault, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

    initial begin
        pats[0] = 8'h3C; pats[1] = 8'hA5; pats[2] = 8'h81; pats[3] = 8'h6E;
        txw[0]  = 8'hA7; txw[1]  = 8'h1E; txw[2]  = 8'hF0; txw[3]  = 8'h55;
        t_reset();
        t_burst(2, 0, 0, 0, 0, 1, "mode0");
        t_burst(1, 0, 1, 0, 0, 1, "mode1");
        t_burst(2, 1, 0, 0, 0, 1, "mode2");
        t_burst(2, 1, 1, 0, 0, 1, "mode3");
        t_burst(3, 0, 0, 1, 0, 1, "pulse mode0");
        t_burst(3, 1, 0, 1, 0, 1, "pulse mode2");
        t_burst(2, 0, 1, 1, 0, 1, "pulse ignored cpha1");
        t_burst(2, 0, 0, 1, 0, 0, "pulse ignored input mode");
        t_burst(2, 0, 0, 1, 1, 1, "pulse ignored software select");
        t_fault();
        t_soft();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

endmodule